// File: doc/BRIEF.md
# Constant Off-Time Current Chopper

This block regulates the current of one full bridge by chopping. While the bridge is driving, the low-side switch conducts and the current climbs. When the external sense comparator reports that the sensed current is above its reference, the block ends the drive phase. It then runs a fixed off-time interval during which the current recirculates through the two upper switches, which gives slow decay. The block then brings the low-side switch back on. The off interval has a fixed length, so the chopping frequency follows the load and is not set by a clock divider.

The off interval has three parts, in this order: a dead time with every switch open, then synchronous rectification on the upper switch, then a second dead time before the low-side switch turns on again. Two guards protect the drive phase. First, a blanking window follows every rising edge of the low-side gate indication, and the comparator is ignored inside it, so the diode recovery spike cannot end the drive phase. Second, a minimum drive time applies; a trip that arrives inside it takes effect only if the comparator is still high when the minimum has elapsed. All four intervals are run-time inputs counted in clock cycles. The configuration must keep `off_cyc_i > dead_cyc_i >= 1`.

Top module: `cot_chopper`

## Requirements
- R1: While reset is held, and while `en_i` is low, `phase_o` is 0 (idle) and `chop_on_o` is 0. One clock edge after `en_i` is seen high in idle, `phase_o` becomes 1 (drive) and `chop_on_o` becomes 1.
- R2: In the drive phase, a comparator trip that is not blanked and comes after the minimum drive time moves `phase_o` to 2 (first dead time) on the next edge.
- R3: The phase codes always follow the cycle 1 (drive), 2 (first dead time), 3 (synchronous rectification), 4 (second dead time), then 1 again. No phase is skipped. `chop_on_o` is 1 only in phase 1.
- R4: Phases 2 and 4 each last exactly `dead_cyc_i` cycles. Phase 3 lasts `off_cyc_i - dead_cyc_i` cycles, so the time out of drive is `off_cyc_i + dead_cyc_i` cycles.
- R5: During phases 2, 3 and 4 the comparator has no effect: a trip that is held high neither restarts nor lengthens the off interval.
- R6: The first clock edge that samples `gate_on_i` high after it was low starts a blanking window. The window covers that edge and the next `blank_cyc_i - 1` edges, and the comparator is ignored at all of them.
- R7: The drive phase lasts at least `minon_cyc_i` cycles. A trip asserted earlier and still high at that point ends the drive phase exactly then.
- R8: Bringing `en_i` low returns the block to idle on the next edge from any phase and clears every timer. A later enable starts a new drive phase with a full minimum drive time and a fresh blanking window.
- R9: A trip pulse that ends before the minimum drive time has elapsed is dropped. The drive phase then continues until a later trip.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| en_i | input | 1 | Bridge enable; low forces idle |
| trip_i | input | 1 | Sense comparator: current above reference |
| gate_on_i | input | 1 | Low-side gate is on (from the gate driver) |
| off_cyc_i | input | CNT_W | Monostable length in cycles (first dead time plus rectification) |
| dead_cyc_i | input | CNT_W | Dead time in cycles |
| blank_cyc_i | input | CNT_W | Blanking window in cycles |
| minon_cyc_i | input | CNT_W | Minimum drive time in cycles |
| chop_on_o | output | 1 | Low-side drive command |
| phase_o | output | 3 | Phase: 0 idle, 1 drive, 2 dead, 3 sync rectify, 4 dead |

## Verification
The bench drives configurations in which, in turn, the trip time, the blanking window and the minimum drive time set the length of the drive phase. A design that combined the two guards wrongly, or that counted a window one cycle short or long, would end the drive phase one cycle early or late. The comparator is kept high through the whole off interval and into the next drive phase. A monostable that retriggers would lengthen the rectification phase, and a blanker that is missing would end the second drive phase at once. Further directed cases cover a short trip pulse inside the minimum drive time, which a latching design would act on, and a disable in the middle of rectification or drive. A block that kept stale timers after the disable would give a short first drive phase after it is enabled again.

// File: rtl/cot_chop_pkg.sv
`timescale 1ns/1ps
// Shared phase encoding for the constant off-time chopper.
// Assumes: the gate logic downstream decodes these exact code values.
package cot_chop_pkg;
    typedef enum logic [2:0] {
        PH_IDLE   = 3'd0,
        PH_ON     = 3'd1,
        PH_DEAD_A = 3'd2,
        PH_SYNC   = 3'd3,
        PH_DEAD_B = 3'd4
    } chop_phase_e;
endpackage

// File: rtl/cot_chop_blank.sv
`timescale 1ns/1ps
// Blanking timer: masks the sense comparator for blank_cyc_i edges,
// starting at the edge that first sees the low-side gate indication high.
// Assumes: clr_i is held while the bridge is disabled.
module cot_chop_blank #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             gate_on_i,
    input  logic [CNT_W-1:0] blank_cyc_i,
    output logic             mask_o
);
    logic             gate_q;
    logic [CNT_W-1:0] left_q;
    logic             rise;

    // Edge detect on the gate indication.
    always_comb rise = gate_on_i && !gate_q;

    // Comparator is masked on the rising edge and while the window runs.
    always_comb mask_o = (rise && (blank_cyc_i != '0)) || (left_q != '0);

    // Window counter: loads on a gate rise, then counts down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            gate_q <= 1'b0;
            left_q <= '0;
        end else begin
            gate_q <= gate_on_i;
            if (rise)
                left_q <= (blank_cyc_i == '0) ? '0 : blank_cyc_i - 1'b1;
            else if (left_q != '0)
                left_q <= left_q - 1'b1;
        end
    end

    // R6: a window longer than one edge is still masking on the next edge.
    a_r6_window_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && rise && blank_cyc_i > 1 && $stable(blank_cyc_i)) |=> (mask_o || clr_i));
endmodule

// File: rtl/cot_chop_minon.sv
`timescale 1ns/1ps
// Minimum drive-time timer: counts the cycles spent in the drive phase and
// reports when the drive phase may end.
// Assumes: in_on_i is high exactly while the sequencer is in the drive phase.
module cot_chop_minon #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_on_i,
    input  logic [CNT_W-1:0] minon_cyc_i,
    output logic             min_ok_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] on_cnt_q;
    logic [CNT_W:0]   on_len;

    // Cycles already spent in drive, counting the present one.
    always_comb on_len = {1'b0, on_cnt_q} + 1'b1;
    always_comb min_ok_o = in_on_i && (on_len >= {1'b0, minon_cyc_i});

    // Saturating drive-time counter, cleared outside the drive phase.
    always_ff @(posedge clk) begin
        if (!rst_n || !in_on_i)
            on_cnt_q <= '0;
        else if (on_cnt_q != CNT_MAX)
            on_cnt_q <= on_cnt_q + 1'b1;
    end

    // R7: once the minimum is met it stays met for the rest of the drive phase.
    a_r7_ok_monotone: assert property (@(posedge clk) disable iff (!rst_n)
        (min_ok_o && $stable(minon_cyc_i)) |=> (!in_on_i || min_ok_o || !$stable(minon_cyc_i)));
endmodule

// File: rtl/cot_chop_seq.sv
`timescale 1ns/1ps
// Phase sequencer: drive, dead time, synchronous rectification, dead time.
// The off-time monostable spans the first dead time and the rectification.
// Assumes: off_cyc_i > dead_cyc_i >= 1 while enabled.
module cot_chop_seq
    import cot_chop_pkg::*;
#(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             trip_ok_i,
    input  logic [CNT_W-1:0] off_cyc_i,
    input  logic [CNT_W-1:0] dead_cyc_i,
    output chop_phase_e      phase_o
);
    chop_phase_e      phase_q;
    logic [CNT_W-1:0] tmr_q;
    logic [CNT_W:0]   tmr_p1;

    // Elapsed cycles in the running interval, counting the present one.
    always_comb tmr_p1 = {1'b0, tmr_q} + 1'b1;

    // Phase and interval timer update.
    always_ff @(posedge clk) begin
        if (!rst_n || !en_i) begin
            phase_q <= PH_IDLE;
            tmr_q   <= '0;
        end else begin
            case (phase_q)
                PH_IDLE: begin
                    phase_q <= PH_ON;
                    tmr_q   <= '0;
                end
                PH_ON: begin
                    tmr_q <= '0;
                    if (trip_ok_i) phase_q <= PH_DEAD_A;
                end
                PH_DEAD_A: begin
                    tmr_q <= tmr_q + 1'b1;
                    if (tmr_p1 >= {1'b0, dead_cyc_i}) phase_q <= PH_SYNC;
                end
                PH_SYNC: begin
                    if (tmr_p1 >= {1'b0, off_cyc_i}) begin
                        phase_q <= PH_DEAD_B;
                        tmr_q   <= '0;
                    end else begin
                        tmr_q <= tmr_q + 1'b1;
                    end
                end
                PH_DEAD_B: begin
                    if (tmr_p1 >= {1'b0, dead_cyc_i}) begin
                        phase_q <= PH_ON;
                        tmr_q   <= '0;
                    end else begin
                        tmr_q <= tmr_q + 1'b1;
                    end
                end
                default: begin
                    phase_q <= PH_IDLE;
                    tmr_q   <= '0;
                end
            endcase
        end
    end

    always_comb phase_o = phase_q;

    // R1: an enabled idle block enters drive on the next edge.
    a_r1_start: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && phase_q == PH_IDLE) |=> phase_q == PH_ON);
    // R3: drive is left only for the first dead time.
    a_r3_after_on: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && phase_q == PH_ON) |=> (phase_q == PH_ON || phase_q == PH_DEAD_A));
    // R3: the first dead time leads only to rectification.
    a_r3_after_dead_a: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && phase_q == PH_DEAD_A) |=> (phase_q == PH_DEAD_A || phase_q == PH_SYNC));
    // R3: rectification leads only to the second dead time.
    a_r3_after_sync: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && phase_q == PH_SYNC) |=> (phase_q == PH_SYNC || phase_q == PH_DEAD_B));
    // R4: drive resumes only through the second dead time.
    a_r4_dead_before_on: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && phase_q == PH_DEAD_B) |=> (phase_q == PH_DEAD_B || phase_q == PH_ON));
    // R8: disable forces idle on the next edge.
    a_r8_disable_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> phase_q == PH_IDLE);
endmodule

// File: rtl/cot_chopper.sv
`timescale 1ns/1ps
// Constant off-time current chopper for one bridge. Combines the blanking
// timer, the minimum drive-time timer and the phase sequencer.
// Assumes: trip_i and gate_on_i are synchronous to clk; off_cyc_i > dead_cyc_i >= 1.
module cot_chopper
    import cot_chop_pkg::*;
#(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             trip_i,
    input  logic             gate_on_i,
    input  logic [CNT_W-1:0] off_cyc_i,
    input  logic [CNT_W-1:0] dead_cyc_i,
    input  logic [CNT_W-1:0] blank_cyc_i,
    input  logic [CNT_W-1:0] minon_cyc_i,
    output logic             chop_on_o,
    output logic [2:0]       phase_o
);
    chop_phase_e phase;
    logic        mask;
    logic        min_ok;
    logic        in_on;
    logic        trip_ok;

    // Drive-phase flag shared by the timers.
    always_comb in_on = (phase == PH_ON);
    // A trip counts only when unblanked and past the minimum drive time.
    always_comb trip_ok = trip_i && !mask && min_ok;

    cot_chop_blank #(.CNT_W(CNT_W)) u_blank (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr_i      (!en_i),
        .gate_on_i  (gate_on_i),
        .blank_cyc_i(blank_cyc_i),
        .mask_o     (mask)
    );

    cot_chop_minon #(.CNT_W(CNT_W)) u_minon (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_on_i    (in_on),
        .minon_cyc_i(minon_cyc_i),
        .min_ok_o   (min_ok)
    );

    cot_chop_seq #(.CNT_W(CNT_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_i      (en_i),
        .trip_ok_i (trip_ok),
        .off_cyc_i (off_cyc_i),
        .dead_cyc_i(dead_cyc_i),
        .phase_o   (phase)
    );

    // Output drive: low-side command and phase code for the gate logic.
    always_comb begin
        chop_on_o = in_on;
        phase_o   = phase;
    end

    // R2: an accepted trip ends drive on the next edge.
    a_r2_trip_ends_on: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && in_on && trip_i && !mask && min_ok) |=> phase_o == 3'd2);
    // R6: a blanked comparator cannot end drive.
    a_r6_blank_holds_on: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && in_on && mask) |=> chop_on_o);
    // R7: drive continues until the minimum drive time is met.
    a_r7_min_on: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && in_on && !min_ok) |=> chop_on_o);
    // R5: the off phases never return to drive before the second dead time.
    a_r5_no_early_on: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_o == 3'd2 || phase_o == 3'd3) |=> !chop_on_o);
endmodule

// File: tb/cot_chopper_tb.sv
`timescale 1ns/1ps
module cot_chopper_tb;
    localparam int W  = 12;
    localparam int NV = 6;
    // Columns: off, dead, blank, min-on, trip edge, expected drive length
    localparam int VEC [NV][6] = '{
        '{20, 2, 3,  4,  1,  4},
        '{30, 3, 2, 10,  5, 10},
        '{16, 1, 8,  2,  3,  9},
        '{25, 4, 3,  3, 15, 15},
        '{10, 5, 1,  1,  1,  2},
        '{40, 2, 6,  6,  7,  7}
    };

    logic clk = 1'b0, rst_n = 1'b0, en = 1'b0, trip = 1'b0, gate = 1'b0;
    logic [W-1:0] off_c = 20, dead_c = 2, blank_c = 1, minon_c = 1;
    logic chop_on;
    logic [2:0] phase;
    int nchk = 0, nfail = 0, nidx = 0;
    int t_set = 0, t_clr = 0, t_set2 = 0;
    bit done = 0;

    always #4 clk = ~clk;

    cot_chopper #(.CNT_W(W)) u_dut (
        .clk(clk), .rst_n(rst_n), .en_i(en), .trip_i(trip), .gate_on_i(gate),
        .off_cyc_i(off_c), .dead_cyc_i(dead_c), .blank_cyc_i(blank_c),
        .minon_cyc_i(minon_c), .chop_on_o(chop_on), .phase_o(phase)
    );

    task automatic chk(string tag, int act, int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Advance to the next falling edge; model the gate driver and trip schedule.
    task automatic step();
        @(negedge clk);
        nidx++;
        gate = (phase == 3'd1);
        if (nidx == t_set)  trip = 1'b1;
        if (nidx == t_clr)  trip = 1'b0;
        if (nidx == t_set2) trip = 1'b1;
    endtask

    task automatic seg_len(input logic [2:0] ph, output int n);
        n = 0;
        while (phase == ph && n < 5000) begin
            n++;
            step();
        end
    endtask

    function automatic int emax(int a, int b);
        return (a > b) ? a : b;
    endfunction

    task automatic arm(int o, int d, int b, int m, int ts, int tc, int ts2);
        off_c = o; dead_c = d; blank_c = b; minon_c = m;
        t_set = ts; t_clr = tc; t_set2 = ts2; nidx = 0;
        en = 1'b1;
        step();
    endtask

    task automatic disarm();
        en = 1'b0;
        trip = 1'b0;
        step();
        step();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            nchk++;
            nfail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

    initial begin
        int l1, la, ls, lb, l2;
        repeat (3) @(negedge clk);
        chk("R1 reset phase", phase, 0);
        chk("R1 reset chop_on", chop_on, 0);
        rst_n = 1'b1;
        step();
        step();
        chk("R1 disabled stays idle", phase, 0);

        // Table walk: drive length, off sequence, second drive with trip held.
        for (int v = 0; v < NV; v++) begin
            arm(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3], VEC[v][4], 0, 0);
            chk("R1 enable enters drive", chop_on, 1);
            seg_len(3'd1, l1);
            chk("R2/R6/R7 drive length", l1, VEC[v][5]);
            chk("R3 drive ends in first dead time", phase, 2);
            seg_len(3'd2, la);
            chk("R4 first dead time", la, VEC[v][1]);
            seg_len(3'd3, ls);
            chk("R5 rectification with trip high", ls, VEC[v][0] - VEC[v][1]);
            seg_len(3'd4, lb);
            chk("R4 second dead time", lb, VEC[v][1]);
            chk("R3 returns to drive", phase, 1);
            seg_len(3'd1, l2);
            chk("R6/R7 second drive with trip held", l2, emax(VEC[v][3], VEC[v][2] + 1));
            disarm();
            chk("R8 idle after disable", phase, 0);
        end

        // R9: short pulse inside minimum drive time is dropped.
        arm(20, 2, 1, 10, 3, 4, 15);
        seg_len(3'd1, l1);
        chk("R9 short pulse dropped", l1, 15);
        disarm();

        // R8: disable during rectification, then re-enable with trip high.
        arm(30, 2, 1, 4, 1, 0, 0);
        while (phase != 3'd3 && nidx < 200) step();
        chk("R3 reached rectification", phase, 3);
        en = 1'b0;
        step();
        chk("R8 disable from rectification", phase, 0);
        chk("R8 chop_on low when idle", chop_on, 0);
        en = 1'b1;
        step();
        seg_len(3'd1, l1);
        chk("R8 fresh minimum after re-enable", l1, 4);
        disarm();

        // R8: disable inside drive, re-enable with trip already high.
        arm(30, 2, 5, 3, 2, 0, 0);
        step();
        en = 1'b0;
        step();
        chk("R8 disable from drive", phase, 0);
        en = 1'b1;
        step();
        seg_len(3'd1, l1);
        chk("R8 fresh blanking after re-enable", l1, 6);
        disarm();

        done = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule